// File: doc/BRIEF.md
# Packed Dual-Entry Colour Lookup Table

This block is the colour lookup table of a display pipeline. It holds 256 colour entries, packed two to a 32-bit word, so software sees 128 words. A bus-side port writes a whole word and reads it back unchanged. A display-side port takes an 8-bit pixel index and returns a 24-bit RGB colour on the next cycle.

Each 16-bit half of a word is one colour. Its three 5-bit fields are red, green and blue, and its top bit is an intensity flag that the colour path ignores. When a word is written, both halves are stored at once as colour entries. The even entry goes to one bank and the odd entry to another, so a lookup needs only a bank select and wiring to widen each component. A valid flag for each word, cleared by reset, makes every entry read as zero until it is written. The storage itself therefore needs no reset and can map onto block RAM.

Top module: `dual_entry_palette`

## Requirements
- R1: After a synchronous reset, rd_data and lk_rgb are zero. Every word reads as zero on the bus port, and every entry looks up as zero, until that word is written.
- R2: A bus read of word n returns, one cycle after rd_idx = n is sampled, the full 32-bit word last written to n, intensity bits included.
- R3: Word n supplies entry 2n from wr_data[15:0] and entry 2n+1 from wr_data[31:16]. Entry index bit 0 selects the half.
- R4: Within a 16-bit half, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. On lk_rgb, red is [23:16], green is [15:8] and blue is [7:0].
- R5: Each 5-bit component c appears on its output byte as c shifted left by 3, with the low three bits zero.
- R6: The intensity bit of a half (bit 15 or bit 31 of the word) has no effect on lk_rgb.
- R7: lk_rgb shows the entry whose index was sampled at the previous clock edge. The latency is exactly one cycle, and a new index is accepted on every cycle.
- R8: When a write and a lookup address the same word in the same cycle, the lookup returns the value held before that write. The new value is seen from the next lookup.
- R9: When a write and a bus read address the same word in the same cycle, the bus read returns the word held before that write.
- R10: Writes to other words do not change the lookup result or the bus read result. Both read ports run every cycle, whatever the write port is doing.
- R11: A reset after the table has been written clears every entry back to zero. A write presented while reset is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one packed word |
| wr_idx | input | 7 | Word index of the write |
| wr_data | input | 32 | Packed word: odd entry high, even entry low |
| rd_idx | input | 7 | Word index of the bus read |
| rd_data | output | 32 | Raw word, one cycle after rd_idx |
| lk_idx | input | 8 | Entry index of the lookup |
| lk_rgb | output | 24 | Expanded colour, one cycle after lk_idx |

## Verification
The table is filled with a word pattern that differs for each word, so that any swapped half or misaddressed word shows up when all 256 entries and all 128 words are read back. A single set bit is then walked through each half. Each position lights exactly one output bit, which separates a wrong field position from a wrong shift. Words with the intensity bits set show that the bus port keeps those bits while the colour path drops them. Same-cycle write/read collisions on both ports, long runs of pseudo-random mixed traffic and a reset in the middle of the run are each compared, on every clock, against a behavioural model in the bench.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // Default geometry of the lookup table
  localparam int PAL_IDX_W  = 8;  // entry index width (256 entries)
  localparam int PAL_COMP_W = 5;  // stored bits per colour component
  localparam int PAL_CH_W   = 8;  // output bits per colour channel

  // Component order inside a half and on the output (red first / highest)
  typedef enum int {CH_RED = 0, CH_GREEN = 1, CH_BLUE = 2} pal_ch_e;
  localparam int PAL_NUM_CH = 3;
endpackage

// File: rtl/pal_ram.sv
// Simple dual-port storage, read-first, registered read, no reset on contents
module pal_ram #(
  parameter int DW = 16,
  parameter int AW = 7,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rq <= mem[ra];
  end
endmodule

// File: rtl/pal_flags.sv
// Per-word written flags; reset to zero, two registered read ports
module pal_flags #(
  parameter int AW = 7,
  localparam int WORDS = 1 << AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [AW-1:0]    set_idx,
  input  logic [AW-1:0]    a_idx,
  input  logic [AW-1:0]    b_idx,
  output logic             a_q,
  output logic             b_q,
  output logic [WORDS-1:0] flags_o
);
  logic [WORDS-1:0] flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      a_q   <= 1'b0;
      b_q   <= 1'b0;
    end else begin
      if (set_en) flags[set_idx] <= 1'b1;
      a_q <= flags[a_idx];
      b_q <= flags[b_idx];
    end
  end

  assign flags_o = flags;
endmodule

// File: rtl/dual_entry_palette.sv
module dual_entry_palette
  import pal_pkg::*;
#(
  parameter int IDX_W  = PAL_IDX_W,
  parameter int COMP_W = PAL_COMP_W,
  parameter int CH_W   = PAL_CH_W,
  localparam int WA_W   = IDX_W - 1,
  localparam int WORDS  = 1 << WA_W,
  localparam int COL_W  = PAL_NUM_CH * COMP_W,
  localparam int HALF_W = COL_W + 1,
  localparam int WORD_W = 2 * HALF_W,
  localparam int RGB_W  = PAL_NUM_CH * CH_W,
  localparam int PAD_W  = CH_W - COMP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WA_W-1:0]   wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WA_W-1:0]   rd_idx,
  output logic [WORD_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [RGB_W-1:0]  lk_rgb
);
  logic              wr_go;
  logic              rd_vld, lk_vld;
  logic [WORDS-1:0]  flags;
  logic [WORD_W-1:0] raw_q;
  logic [COL_W-1:0]  col_q [2];
  logic              lk_sel_q;
  logic [COL_W-1:0]  sel_col;

  assign wr_go = wr_en & ~rst;

  // Written flags: make unwritten words read as zero without clearing RAM
  pal_flags #(.AW(WA_W)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_en  (wr_go),
    .set_idx (wr_idx),
    .a_idx   (rd_idx),
    .b_idx   (lk_idx[IDX_W-1:1]),
    .a_q     (rd_vld),
    .b_q     (lk_vld),
    .flags_o (flags)
  );

  // Raw word store for bus readback (keeps intensity bits)
  pal_ram #(.DW(WORD_W), .AW(WA_W)) u_raw (
    .clk (clk),
    .we  (wr_go),
    .wa  (wr_idx),
    .wd  (wr_data),
    .ra  (rd_idx),
    .rq  (raw_q)
  );

  // Colour banks: half 0 holds even entries, half 1 holds odd entries
  for (genvar h = 0; h < 2; h++) begin : g_half
    pal_ram #(.DW(COL_W), .AW(WA_W)) u_bank (
      .clk (clk),
      .we  (wr_go),
      .wa  (wr_idx),
      .wd  (wr_data[h*HALF_W +: COL_W]),
      .ra  (lk_idx[IDX_W-1:1]),
      .rq  (col_q[h])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) lk_sel_q <= 1'b0;
    else     lk_sel_q <= lk_idx[0];
  end

  assign sel_col = col_q[lk_sel_q];
  assign rd_data = rd_vld ? raw_q : '0;

  // Component widening: red lands in the top byte, blue in the bottom
  for (genvar c = 0; c < PAL_NUM_CH; c++) begin : g_ch
    assign lk_rgb[(PAL_NUM_CH-1-c)*CH_W +: CH_W] =
      lk_vld ? {sel_col[c*COMP_W +: COMP_W], {PAD_W{1'b0}}} : '0;
  end

  // R1: outputs are cleared by reset
  a_r1_reset_clears_outputs: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0 && lk_rgb == '0));

  // R11: flag store is empty right after reset
  a_r11_flags_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> flags == '0);

  // R2: a word written two cycles back and read one cycle back comes out raw
  a_r2_raw_readback: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en, 2) && !$past(rst, 2) && !$past(rst) &&
     $past(rd_idx) == $past(wr_idx, 2)) |-> rd_data == $past(wr_data, 2));

  // R10: held lookup index with no write to its word keeps the colour steady
  a_r10_lookup_steady: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(lk_idx) == $past(lk_idx, 2) &&
     (!$past(wr_en, 2) || $past(wr_idx, 2) != $past(lk_idx[IDX_W-1:1], 2)))
    |-> $stable(lk_rgb));

  // R10: same for the bus read port
  a_r10_bus_steady: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(rd_idx) == $past(rd_idx, 2) &&
     (!$past(wr_en, 2) || $past(wr_idx, 2) != $past(rd_idx, 2)))
    |-> $stable(rd_data));
endmodule

// File: tb/dual_entry_palette_bench.sv
`timescale 1ns/1ps
module dual_entry_palette_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [7:0]  lk_idx = '0;
  logic [23:0] lk_rgb;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  logic [31:0] model [128];
  logic [31:0] lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  dual_entry_palette u_dual_entry_palette (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
  );

  // Reference colour: written arithmetically from the field layout
  function automatic logic [23:0] ref_rgb(input logic [15:0] h);
    int r, g, b;
    r = (int'(h) % 32) * 8;
    g = ((int'(h) / 32) % 32) * 8;
    b = ((int'(h) / 1024) % 32) * 8;
    return 24'(r * 65536 + g * 256 + b);
  endfunction

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg;
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Drive one cycle, predict from the model state before the write, compare
  task automatic step(input logic we, input logic [6:0] wi, input logic [31:0] wd,
                      input logic [6:0] ri, input logic [7:0] li, input logic r);
    logic [31:0] exp_rd;
    logic [23:0] exp_lk;
    logic [31:0] w;
    wr_en = we; wr_idx = wi; wr_data = wd; rd_idx = ri; lk_idx = li; rst = r;
    if (r) begin
      exp_rd = '0;
      exp_lk = '0;
      for (int i = 0; i < 128; i++) model[i] = '0;
    end else begin
      exp_rd = model[ri];
      w = model[li / 2];
      exp_lk = (li % 2 == 1) ? ref_rgb(w[31:16]) : ref_rgb(w[15:0]);
      if (we) model[wi] = wd;
    end
    @(negedge clk);
    checks++;
    if (rd_data !== exp_rd) begin
      errors++;
      $display("FAIL %s rd_data got %h expected %h", tag, rd_data, exp_rd);
    end
    checks++;
    if (lk_rgb !== exp_lk) begin
      errors++;
      $display("FAIL %s lk_rgb got %h expected %h", tag, lk_rgb, exp_lk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired got hung run expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = '0;
    // R1: reset state and unwritten entries read zero
    tag = "R1";
    repeat (3) step(1'b0, 7'd0, 32'd0, 7'd0, 8'd0, 1'b1);
    for (int i = 0; i < 16; i++) step(1'b0, 7'd0, 32'd0, 7'(i * 7), 8'(i * 13), 1'b0);

    // R2: fill every word with a distinct pattern
    tag = "R2";
    for (int i = 0; i < 128; i++)
      step(1'b1, 7'(i), {16'(i * 977 + 3), 16'(i * 311 + 1)} ^ 32'h5A3C_0000, 7'd0, 8'd1, 1'b0);
    for (int i = 0; i < 128; i++) step(1'b0, 7'd0, 32'd0, 7'(i), 8'd0, 1'b0);

    // R3: every entry, even and odd halves; R7 new index each cycle
    tag = "R3";
    for (int i = 0; i < 256; i++) step(1'b0, 7'd0, 32'd0, 7'(i / 2), 8'(i), 1'b0);
    tag = "R7";
    for (int i = 0; i < 64; i++) step(1'b0, 7'd0, 32'd0, 7'(i), 8'(255 - i * 3), 1'b0);

    // R4, R5: walk one set bit through each half of word 2
    tag = "R4";
    for (int b = 0; b < 15; b++) begin
      step(1'b1, 7'd2, 32'(1) << b, 7'd2, 8'd9, 1'b0);
      step(1'b0, 7'd0, 32'd0, 7'd2, 8'd4, 1'b0);
    end
    tag = "R5";
    for (int b = 0; b < 15; b++) begin
      step(1'b1, 7'd2, 32'(1) << (b + 16), 7'd2, 8'd9, 1'b0);
      step(1'b0, 7'd0, 32'd0, 7'd2, 8'd5, 1'b0);
    end

    // R6: intensity bits kept on bus, ignored by lookup
    tag = "R6";
    step(1'b1, 7'd9, 32'hFFFF_FFFF, 7'd0, 8'd0, 1'b0);
    step(1'b1, 7'd10, 32'h7FFF_7FFF, 7'd9, 8'd18, 1'b0);
    step(1'b1, 7'd11, 32'h8000_8000, 7'd10, 8'd19, 1'b0);
    step(1'b0, 7'd0, 32'd0, 7'd11, 8'd20, 1'b0);
    step(1'b0, 7'd0, 32'd0, 7'd9, 8'd22, 1'b0);
    step(1'b0, 7'd0, 32'd0, 7'd9, 8'd23, 1'b0);

    // R8: same-cycle write and lookup return the old colour
    tag = "R8";
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 7'(40 + i), rnd(), 7'd0, 8'((40 + i) * 2 + (i % 2)), 1'b0);
      step(1'b0, 7'd0, 32'd0, 7'd0, 8'((40 + i) * 2 + (i % 2)), 1'b0);
    end

    // R9: same-cycle write and bus read return the old word
    tag = "R9";
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 7'(60 + i), rnd(), 7'(60 + i), 8'd0, 1'b0);
      step(1'b0, 7'd0, 32'd0, 7'(60 + i), 8'd0, 1'b0);
    end

    // R10: mixed pseudo-random traffic on all ports
    tag = "R10";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      a = rnd();
      step(a[31], a[6:0], rnd(), a[13:7], a[21:14], 1'b0);
    end

    // R11: reset mid-run, write during reset dropped, everything reads zero
    tag = "R11";
    step(1'b1, 7'd3, 32'hDEAD_BEEF, 7'd3, 8'd6, 1'b1);
    step(1'b0, 7'd0, 32'd0, 7'd3, 8'd7, 1'b0);
    for (int i = 0; i < 128; i++) step(1'b0, 7'd0, 32'd0, 7'(i), 8'(2 * i + 1), 1'b0);

    summary();
    $finish;
  end
endmodule